// File: doc/BRIEF.md
# Receive Descriptor Status Writer

This block produces the status words that a receive channel leaves in its descriptor ring once a frame has been stored in host memory. When a frame of a given byte count is offered and receive is enabled, the block spreads it over fixed-size buffers. It issues one descriptor write per cycle. Each intermediate descriptor gets the buffer size as its length. The closing descriptor gets a last-segment flag and an adjusted length, which is the bytes left in the final buffer plus the CRC byte count plus one.

The CRC byte count comes from a per-channel control register. The code 0x0A selects four bytes. The code 0x08, and every other code, selects two. When a frame closes normally, the block raises a one-cycle receive interrupt request. If the descriptor it is about to fill still belongs to the host, it abandons the frame, raises no interrupt, and rewinds its ring pointer to the frame's first descriptor. Moving the payload and checking the CRC are handled elsewhere.

Top module: `rxd_status_writer`

## Requirements
- R1: `frm_ready` is high exactly when the block is idle. An offer (`frm_valid` high while idle) is taken as a frame only if `rx_en` is high. Otherwise it is consumed with no descriptor write and no interrupt, and the block stays idle.
- R2: While more than BUF_BYTES bytes of the frame remain, each descriptor write carries a word equal to BUF_BYTES: the length sits in bits 15:0 and all other bits are zero. The remaining count then drops by BUF_BYTES.
- R3: The closing write is made when 0 to BUF_BYTES bytes remain. Its word has bit 30 (last segment) set and bits 15:0 equal to remaining + CRC byte count + 1, taken to 16 bits.
- R4: The CRC byte count is 4 when the control register holds 0x000A, and 2 for any other value, including 0x0008 and the reset value 0.
- R5: `ctrl_rdata` returns the last value written through `ctrl_wr`/`ctrl_wdata`, effective the cycle after the write. It is 0 after reset.
- R6: In every descriptor word, bits 31, 29:16 are zero. This includes the error flags at bit 27 (ignored), bit 26 (abort) and bit 25 (CRC error).
- R7: `rx_irq` is a one-cycle pulse. It is high in exactly the cycle of a closing descriptor write and at no other time.
- R8: `dw_index` is 0 after reset. The first write comes in the cycle after a frame is taken, and writes then follow one per cycle. Each write advances `dw_index` by one in the next cycle, wrapping from RING_DEPTH-1 to 0. When not writing, `dw_valid` is low and `dw_word` is 0.
- R9: If `desc_avail` is low in a cycle where a write is due, no write is made, no interrupt is raised for that frame, and the block goes idle. `dw_index` returns to the index where the frame started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled when a frame is offered |
| frm_valid | input | 1 | Frame offer |
| frm_len | input | LEN_W | Byte count of the offered frame |
| frm_ready | output | 1 | Block idle, able to take an offer |
| desc_avail | input | 1 | Descriptor at `dw_index` is owned by the device |
| ctrl_wr | input | 1 | Write strobe of the CRC control register |
| ctrl_wdata | input | CTRL_W | Value written to the CRC control register |
| ctrl_rdata | output | CTRL_W | Current CRC control register value |
| dw_valid | output | 1 | Descriptor status write this cycle |
| dw_index | output | IDX_W | Ring index of the descriptor being written |
| dw_word | output | 32 | Descriptor status word |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The bench builds the block with BUF_BYTES = 16 and RING_DEPTH = 4. With these values, frames of a few dozen bytes already span several buffers, including a length that is an exact multiple of the buffer. A handful of frames also carries the ring pointer across its wrap point. The CRC code is changed between frames so that 0x08, 0x0A and an unlisted code each reach a closing word. A host-owned descriptor is forced in the middle of a multi-buffer frame to show the rewind.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int LAST_SEG_BIT = 30;

  // CRC byte count selected by a control code
  function automatic logic [2:0] crc_bytes(input logic [31:0] code);
    if (code == 32'h0000_000A) return 3'd4;
    return 3'd2;
  endfunction

  // Status word of a non-final descriptor: buffer length only
  function automatic logic [31:0] chunk_status(input logic [31:0] nbytes);
    return {16'h0000, nbytes[15:0]};
  endfunction

  // Status word of the closing descriptor
  function automatic logic [31:0] final_status(input logic [31:0] rest,
                                                input logic [2:0]  crc);
    logic [31:0] sum;
    sum = rest + 32'(crc) + 32'd1;
    return (32'd1 << LAST_SEG_BIT) | {16'h0000, sum[15:0]};
  endfunction

endpackage

// File: rtl/rxd_crc_ctrl.sv
module rxd_crc_ctrl #(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [2:0]        crc_size
);
  import rxd_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata;
  end

  assign rdata    = ctrl_q;
  assign crc_size = crc_bytes(32'(ctrl_q));

endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int RING_DEPTH = 8,
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark,
  input  logic             adv,
  input  logic             rewind,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

  logic [IDX_W-1:0] idx_q, start_q, idx_nx;

  always_comb begin
    if (idx_q == LAST_IDX) idx_nx = '0;
    else                   idx_nx = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      start_q <= '0;
    end else begin
      if (mark)        start_q <= idx_q;
      if (rewind)      idx_q   <= start_q;
      else if (adv)    idx_q   <= idx_nx;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/rxd_seg_engine.sv
module rxd_seg_engine #(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             rx_en,
  input  logic             desc_avail,
  input  logic [2:0]       crc_size,
  output logic             frm_ready,
  output logic             dw_valid,
  output logic [31:0]      dw_word,
  output logic             rx_irq,
  output logic             evt_accept,
  output logic             evt_drop,
  output logic             evt_final
);
  import rxd_pkg::*;

  localparam logic [LEN_W-1:0] BUF_L = LEN_W'(BUF_BYTES);

  typedef enum logic {S_IDLE, S_WRITE} state_t;

  state_t           state_q;
  logic [LEN_W-1:0] rem_q;
  logic             more;

  assign frm_ready  = (state_q == S_IDLE);
  assign evt_accept = frm_ready && frm_valid && rx_en;
  assign more       = (rem_q > BUF_L);
  assign dw_valid   = (state_q == S_WRITE) && desc_avail;
  assign evt_drop   = (state_q == S_WRITE) && !desc_avail;
  assign evt_final  = dw_valid && !more;
  assign rx_irq     = evt_final;

  always_comb begin
    dw_word = '0;
    if (dw_valid) begin
      if (more) dw_word = chunk_status(32'(BUF_BYTES));
      else      dw_word = final_status(32'(rem_q), crc_size);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (evt_accept) begin
          state_q <= S_WRITE;
          rem_q   <= frm_len;
        end
        S_WRITE: begin
          if (evt_drop || evt_final) state_q <= S_IDLE;
          else                       rem_q   <= rem_q - BUF_L;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxd_status_writer.sv
module rxd_status_writer #(
  parameter int LEN_W      = 16,
  parameter int BUF_BYTES  = 64,
  parameter int RING_DEPTH = 8,
  parameter int CTRL_W     = 16,
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              frm_ready,
  input  logic              desc_avail,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic              dw_valid,
  output logic [IDX_W-1:0]  dw_index,
  output logic [31:0]       dw_word,
  output logic              rx_irq
);

  logic [2:0] crc_size;
  logic       evt_accept, evt_drop, evt_final;

  rxd_crc_ctrl #(.CTRL_W(CTRL_W)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_wr),
    .wdata    (ctrl_wdata),
    .rdata    (ctrl_rdata),
    .crc_size (crc_size)
  );

  rxd_seg_engine #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_seg (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_len    (frm_len),
    .rx_en      (rx_en),
    .desc_avail (desc_avail),
    .crc_size   (crc_size),
    .frm_ready  (frm_ready),
    .dw_valid   (dw_valid),
    .dw_word    (dw_word),
    .rx_irq     (rx_irq),
    .evt_accept (evt_accept),
    .evt_drop   (evt_drop),
    .evt_final  (evt_final)
  );

  rxd_ring_ptr #(.RING_DEPTH(RING_DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mark   (evt_accept),
    .adv    (dw_valid),
    .rewind (evt_drop),
    .idx    (dw_index)
  );

endmodule

// File: rtl/rxd_status_writer_chk.sv
module rxd_status_writer_chk #(
  parameter int BUF_BYTES  = 64,
  parameter int RING_DEPTH = 8,
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             dw_valid,
  input logic [IDX_W-1:0] dw_index,
  input logic [31:0]      dw_word,
  input logic             rx_irq,
  input logic [2:0]       crc_size,
  input logic             evt_drop
);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return (32'(i) >= RING_DEPTH - 1) ? '0 : IDX_W'(32'(i) + 1);
  endfunction

  p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> !dw_valid);

  p_reject_stays_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready && frm_valid && !rx_en |=> frm_ready);

  p_chunk_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && !dw_word[30] |-> dw_word == 32'(BUF_BYTES));

  p_crc_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crc_size == 3'd2 || crc_size == 3'd4);

  p_clean_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |-> dw_word[31] == 1'b0 && dw_word[29:16] == '0);

  p_irq_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> dw_valid && dw_word[30]);

  p_last_gives_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && dw_word[30] |-> rx_irq);

  p_index_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |=> dw_index == step_idx($past(dw_index)));

  p_drop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |-> !rx_irq ##1 frm_ready);

endmodule

bind rxd_status_writer rxd_status_writer_chk #(
  .BUF_BYTES(BUF_BYTES), .RING_DEPTH(RING_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
  .frm_ready(frm_ready), .dw_valid(dw_valid), .dw_index(dw_index),
  .dw_word(dw_word), .rx_irq(rx_irq), .crc_size(crc_size),
  .evt_drop(evt_drop)
);

// File: tb/rxd_status_writer_bench.sv
module rxd_status_writer_bench;

  localparam int LEN_W = 16, BUF = 16, RING = 4, CTRL_W = 16;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, frm_valid = 1'b0, desc_avail = 1'b1, ctrl_wr = 1'b0;
  logic [LEN_W-1:0]  frm_len = '0;
  logic [CTRL_W-1:0] ctrl_wdata = '0;
  logic              frm_ready, dw_valid, rx_irq;
  logic [CTRL_W-1:0] ctrl_rdata;
  logic [IDX_W-1:0]  dw_index;
  logic [31:0]       dw_word;

  always #10 clk = ~clk;

  rxd_status_writer #(.LEN_W(LEN_W), .BUF_BYTES(BUF), .RING_DEPTH(RING),
                      .CTRL_W(CTRL_W)) u_rxd_status_writer (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
    .frm_len(frm_len), .frm_ready(frm_ready), .desc_avail(desc_avail),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .dw_valid(dw_valid), .dw_index(dw_index), .dw_word(dw_word),
    .rx_irq(rx_irq)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_busy = 0;
  int m_rem = 0, m_idx = 0, m_start = 0, m_ctrl = 0;

  task automatic cmp(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int  crc, e_word;
    bit  e_valid, e_irq;
    #1;
    crc     = (m_ctrl == 10) ? 4 : 2;
    e_valid = m_busy && desc_avail;
    e_irq   = e_valid && (m_rem <= BUF);
    e_word  = 0;
    if (e_valid) e_word = (m_rem > BUF) ? BUF : ((1 << 30) | ((m_rem + crc + 1) % 65536));
    cmp("R1 frm_ready", frm_ready, !m_busy);
    cmp("R8 R9 dw_valid", dw_valid, e_valid);
    cmp("R8 R9 dw_index", dw_index, m_idx);
    cmp("R5 ctrl_rdata", ctrl_rdata, m_ctrl);
    cmp("R7 rx_irq", rx_irq, e_irq);
    if (e_valid && m_rem > BUF) cmp("R2 R6 chunk word", dw_word, e_word);
    else if (e_valid)          cmp("R3 R4 R6 final word", dw_word, e_word);
    else                       cmp("R8 idle word", dw_word, 0);
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_rem = 0; m_idx = 0; m_start = 0; m_ctrl = 0;
    end else begin
      if (!m_busy) begin
        if (frm_valid && rx_en) begin
          m_busy = 1; m_rem = frm_len; m_start = m_idx;
        end
      end else if (!desc_avail) begin
        m_busy = 0; m_idx = m_start;
      end else begin
        if (m_rem > BUF) m_rem -= BUF;
        else             m_busy = 0;
        m_idx = (m_idx + 1) % RING;
      end
      if (ctrl_wr) m_ctrl = ctrl_wdata;
    end
    @(negedge clk);
  endtask

  task automatic write_ctrl(input int v);
    ctrl_wr = 1; ctrl_wdata = CTRL_W'(v);
    step();
    ctrl_wr = 0;
  endtask

  task automatic offer(input int len, input bit en);
    rx_en = en; frm_valid = 1; frm_len = LEN_W'(len);
    step();
    frm_valid = 0;
    for (int k = 0; k < 100 && m_busy; k++) step();
    step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();              // reset state
    rst_n = 1;
    step();
    write_ctrl(8);                  // R5, R4: 0x08 -> 2
    offer(10, 1);                   // R3 single buffer
    offer(12, 0);                   // R1 rejected
    write_ctrl(10);                 // R4: 0x0A -> 4
    offer(40, 1);                   // R2 split 16,16,8
    offer(32, 1);                   // R3 exact multiple
    write_ctrl('h33);               // R4 other -> 2
    offer(0, 1);                    // R3 empty frame
    offer(5, 1);                    // R8 wrap
    // R9: host-owned descriptor mid-frame
    rx_en = 1; frm_valid = 1; frm_len = 50;
    step();
    frm_valid = 0;
    step();
    desc_avail = 0;
    step();
    desc_avail = 1;
    step();
    step();
    offer(17, 1);                   // after rewind
    write_ctrl(10);
    for (int f = 1; f < 7; f++) offer(f * 7, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule